// File: doc/BRIEF.md
# FIFO Flag Offset Register Loader

This block sets the four flag thresholds of a two-direction FIFO buffer: the almost-full and almost-empty offsets that each port's flag comparators use. When master reset is released it decodes three configuration pins, which were held steady during reset, and picks one loading method. The method is a fixed preset (64, 16 or 8), a parallel load of four words from the port A write bus, or a bit-serial load through a data pin and an active-low enable pin. Until the offsets are complete it holds the port ready flags low. It then opens the port A write path to FIFO memory and, after a two-flop synchronizer, raises the port B ready flag in the port B clock domain.

Port A writes use a valid/ready handshake. A write is accepted on a `clk_a` rising edge when `wr_valid` and `wr_ready` are both high. The source must hold `wr_valid` and `wr_data` until that edge. While `wr_ready` is low, nothing is accepted and nothing reaches memory. During a parallel load, accepted writes are consumed by the loader. After the load, accepted writes appear on `mem_wr_valid` in the same cycle.

Top module: `ofs_loader`

## Requirements
- R1: While `rst_a_n` and `rst_b_n` are low, `wr_ready` and `rdy_b` are low. With `cfg_mode`=1, `cfg_sel`=11/10/01 loads all four offsets with 64/16/8, and `wr_ready` rises on the first `clk_a` edge after reset release.
- R2: With `cfg_mode`=1 and `cfg_sel`=00 (parallel), `wr_ready` is high after release. The first four accepted writes load `wr_data` into `af_a_ofs`, `ae_b_ofs`, `af_b_ofs`, `ae_a_ofs`, in that order. Cycles with `wr_valid` low are skipped.
- R3: `mem_wr_valid` is low for the four loading writes. Afterwards it equals `wr_valid`. Offsets do not change after loading ends.
- R4: With `cfg_mode`=0 and `cfg_sel`=10 (serial), each `clk_a` edge with `ser_en_n` low shifts in one `ser_din` bit. The bits go MSB first into `af_a_ofs`, `ae_b_ofs`, `af_b_ofs`, `ae_a_ofs`, 4*W bits in total. Edges with `ser_en_n` high are ignored.
- R5: In serial mode `wr_ready` stays low through the last bit and rises on the `clk_a` edge after it. `mem_wr_valid` stays low while `wr_ready` is low, whatever `wr_valid` does.
- R6: `rdy_b` stays low until loading is complete. It then rises through a two-flop `clk_b` synchronizer, within four `clk_b` periods. It is never high while `wr_ready` is low.
- R7: With `cfg_mode`=0 and `cfg_sel` other than 10 (reserved), all offsets stay 64. `mode_err` rises on the first `clk_a` edge after release and holds until reset. `wr_ready` and `rdy_b` stay low.
- R8: The pins `cfg_mode` and `cfg_sel` are sampled only while reset is low. Changes after release have no effect on the offsets or the flags.
- R9: `mode_err` stays low in the preset, parallel and serial modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A master reset, synchronous, active low |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B master reset, synchronous, active low |
| cfg_mode | input | 1 | Loading-mode pin: 1 for preset or parallel, 0 for serial or reserved |
| cfg_sel | input | 2 | Mode select pair, sampled during reset |
| wr_valid | input | 1 | Port A write valid |
| wr_data | input | W | Low data bits of the port A write bus |
| wr_ready | output | 1 | Port A ready flag |
| mem_wr_valid | output | 1 | Accepted write forwarded to FIFO memory |
| ser_din | input | 1 | Serial offset data |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ae_b_ofs | output | W | Port B almost-empty offset |
| af_a_ofs | output | W | Port A almost-full offset |
| ae_a_ofs | output | W | Port A almost-empty offset |
| af_b_ofs | output | W | Port B almost-full offset |
| rdy_b | output | 1 | Port B ready flag, `clk_b` domain |
| mode_err | output | 1 | Reserved mode selected, sticky until reset |

## Verification
The three preset selects are each checked against their constant. The configuration pins are then scrambled after release, which separates sampling during reset from live decoding. Parallel loads use random offsets with random idle gaps on `wr_valid`. This shows that only accepted writes advance the register order, and that the fifth write passes through to memory. Serial loads use random values with random disabled edges that carry junk on `ser_din`; these catch a shift that ignores the enable, and a wrong bit or register order. Every reserved code is tried, which separates reserved codes from the serial code.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;

  typedef enum logic [2:0] {
    LM_PRE64,
    LM_PRE16,
    LM_PRE8,
    LM_PARALLEL,
    LM_SERIAL,
    LM_RESERVED
  } load_mode_e;

  function automatic load_mode_e decode_mode(input logic mode_hi, input logic [1:0] sel);
    load_mode_e m;
    if (mode_hi) begin
      case (sel)
        2'b11:   m = LM_PRE64;
        2'b10:   m = LM_PRE16;
        2'b01:   m = LM_PRE8;
        default: m = LM_PARALLEL;
      endcase
    end else begin
      m = (sel == 2'b10) ? LM_SERIAL : LM_RESERVED;
    end
    return m;
  endfunction

  function automatic int unsigned preset_of(input load_mode_e m);
    int unsigned v;
    case (m)
      LM_PRE16: v = 16;
      LM_PRE8:  v = 8;
      default:  v = 64;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/ofsld_mode_dec.sv
module ofsld_mode_dec
  import ofsld_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             cfg_mode,
  input  logic [1:0]       cfg_sel,
  output load_mode_e       mode,
  output logic [W-1:0]     preset
);

  load_mode_e m_c;
  int unsigned pv_c;

  always_comb begin
    m_c  = decode_mode(cfg_mode, cfg_sel);
    pv_c = preset_of(m_c);
  end

  assign mode   = m_c;
  assign preset = pv_c[W-1:0];

endmodule

// File: rtl/ofsld_ctrl.sv
module ofsld_ctrl
  import ofsld_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk_a,
  input  logic             rst_a_n,
  input  load_mode_e       mode_now,
  input  logic [W-1:0]     preset_now,
  input  logic             wr_valid,
  input  logic [W-1:0]     wr_data,
  input  logic             ser_din,
  input  logic             ser_en_n,
  output logic [4*W-1:0]   ofs_vec,
  output logic             rdy_a,
  output logic             done,
  output logic             err
);

  localparam int TOT   = 4 * W;
  localparam int CNT_W = $clog2(TOT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TOT);
  localparam logic [CNT_W-1:0] CNT_PAR  = CNT_W'(3);

  load_mode_e        mode_q;
  logic [4*W-1:0]    vec_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, rdy_q, err_q;

  always_ff @(posedge clk_a) begin
    if (!rst_a_n) begin
      mode_q <= mode_now;
      vec_q  <= {4{preset_now}};
      cnt_q  <= '0;
      done_q <= 1'b0;
      rdy_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (mode_q)
        LM_PRE64, LM_PRE16, LM_PRE8: begin
          done_q <= 1'b1;
          rdy_q  <= 1'b1;
        end
        LM_PARALLEL: begin
          rdy_q <= 1'b1;
          if (rdy_q && !done_q && wr_valid) begin
            case (cnt_q[1:0])
              2'd0:    vec_q[3*W +: W] <= wr_data;
              2'd1:    vec_q[2*W +: W] <= wr_data;
              2'd2:    vec_q[1*W +: W] <= wr_data;
              default: vec_q[0   +: W] <= wr_data;
            endcase
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_PAR) done_q <= 1'b1;
          end
        end
        LM_SERIAL: begin
          if (!done_q) begin
            if (cnt_q == CNT_LAST) begin
              done_q <= 1'b1;
              rdy_q  <= 1'b1;
            end else if (!ser_en_n) begin
              vec_q <= {vec_q[4*W-2:0], ser_din};
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: err_q <= 1'b1;
      endcase
    end
  end

  assign ofs_vec = vec_q;
  assign rdy_a   = rdy_q;
  assign done    = done_q;
  assign err     = err_q;

endmodule

// File: rtl/ofsld_sync.sv
module ofsld_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofsld_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_a,
  input  logic         rst_a_n,
  input  logic         clk_b,
  input  logic         rst_b_n,
  input  logic         cfg_mode,
  input  logic [1:0]   cfg_sel,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic         mem_wr_valid,
  input  logic         ser_din,
  input  logic         ser_en_n,
  output logic [W-1:0] ae_b_ofs,
  output logic [W-1:0] af_a_ofs,
  output logic [W-1:0] ae_a_ofs,
  output logic [W-1:0] af_b_ofs,
  output logic         rdy_b,
  output logic         mode_err
);

  load_mode_e       mode_c;
  logic [W-1:0]     preset_c;
  logic [4*W-1:0]   vec;
  logic             rdy_a, done, err;

  ofsld_mode_dec #(.W(W)) u_dec (
    .cfg_mode (cfg_mode),
    .cfg_sel  (cfg_sel),
    .mode     (mode_c),
    .preset   (preset_c)
  );

  ofsld_ctrl #(.W(W)) u_ctrl (
    .clk_a      (clk_a),
    .rst_a_n    (rst_a_n),
    .mode_now   (mode_c),
    .preset_now (preset_c),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .ser_din    (ser_din),
    .ser_en_n   (ser_en_n),
    .ofs_vec    (vec),
    .rdy_a      (rdy_a),
    .done       (done),
    .err        (err)
  );

  ofsld_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk   (clk_b),
    .rst_n (rst_b_n),
    .d     (done),
    .q     (rdy_b)
  );

  assign af_a_ofs     = vec[3*W +: W];
  assign ae_b_ofs     = vec[2*W +: W];
  assign af_b_ofs     = vec[1*W +: W];
  assign ae_a_ofs     = vec[0   +: W];
  assign wr_ready     = rdy_a;
  assign mem_wr_valid = wr_valid && rdy_a && done;
  assign mode_err     = err;

endmodule

// File: rtl/ofsld_chk.sv
module ofsld_chk #(
  parameter int W = 8
) (
  input logic         clk_a,
  input logic         rst_a_n,
  input logic         clk_b,
  input logic         rst_b_n,
  input logic         wr_ready,
  input logic         mem_wr_valid,
  input logic [W-1:0] ae_b_ofs,
  input logic [W-1:0] af_a_ofs,
  input logic [W-1:0] ae_a_ofs,
  input logic [W-1:0] af_b_ofs,
  input logic         rdy_b,
  input logic         mode_err
);

  // R1
  rdy_low_in_rst_chk: assert property (@(posedge clk_a) !rst_a_n |=> !wr_ready);

  // R5
  rdy_a_hold_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    wr_ready |=> wr_ready);

  // R6
  rdy_b_after_a_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n || !rst_a_n)
    rdy_b |-> wr_ready);

  // R7
  err_sticky_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    mode_err |=> mode_err);

  // R7
  err_blocks_rdy_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    mode_err |-> !wr_ready);

  // R3
  ofs_frozen_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    mem_wr_valid |=> ($stable(af_a_ofs) && $stable(ae_b_ofs) &&
                      $stable(af_b_ofs) && $stable(ae_a_ofs)));

endmodule

bind ofs_loader ofsld_chk #(.W(W)) u_ofsld_chk (
  .clk_a        (clk_a),
  .rst_a_n      (rst_a_n),
  .clk_b        (clk_b),
  .rst_b_n      (rst_b_n),
  .wr_ready     (wr_ready),
  .mem_wr_valid (mem_wr_valid),
  .ae_b_ofs     (ae_b_ofs),
  .af_a_ofs     (af_a_ofs),
  .ae_a_ofs     (ae_a_ofs),
  .af_b_ofs     (af_b_ofs),
  .rdy_b        (rdy_b),
  .mode_err     (mode_err)
);

// File: tb/ofs_loader_bench.sv
module ofs_loader_bench;

  localparam int W       = 8;
  localparam int CLK_PER = 10;
  localparam int CLKB_PER = 14;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic cfg_mode = 1'b1;
  logic [1:0] cfg_sel = 2'b11;
  logic wr_valid = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic ser_din = 1'b0, ser_en_n = 1'b1;
  logic wr_ready, mem_wr_valid, rdy_b, mode_err;
  logic [W-1:0] ae_b_ofs, af_a_ofs, ae_a_ofs, af_b_ofs;

  int checks = 0, fails = 0;

  always #(CLK_PER/2)  clk_a = ~clk_a;
  always #(CLKB_PER/2) clk_b = ~clk_b;

  ofs_loader #(.W(W)) u_ofs_loader (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
    .cfg_mode(cfg_mode), .cfg_sel(cfg_sel),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .mem_wr_valid(mem_wr_valid), .ser_din(ser_din), .ser_en_n(ser_en_n),
    .ae_b_ofs(ae_b_ofs), .af_a_ofs(af_a_ofs), .ae_a_ofs(ae_a_ofs),
    .af_b_ofs(af_b_ofs), .rdy_b(rdy_b), .mode_err(mode_err)
  );

  function automatic int exp_preset(input logic m, input logic [1:0] s);
    if (m && s == 2'b10) return 16;
    if (m && s == 2'b01) return 8;
    return 64;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req, input int y1, input int x1, input int y2, input int x2);
    chk(req, int'(af_a_ofs), y1);
    chk(req, int'(ae_b_ofs), x1);
    chk(req, int'(af_b_ofs), y2);
    chk(req, int'(ae_a_ofs), x2);
  endtask

  task automatic apply_reset(input logic m, input logic [1:0] s);
    @(negedge clk_a);
    rst_a_n = 1'b0; rst_b_n = 1'b0;
    cfg_mode = m; cfg_sel = s;
    wr_valid = 1'b0; ser_en_n = 1'b1;
    repeat (4) @(negedge clk_a);
    chk("R1 rdy_a in reset", int'(wr_ready), 0);
    chk("R1 rdy_b in reset", int'(rdy_b), 0);
    rst_a_n = 1'b1; rst_b_n = 1'b1;
  endtask

  task automatic wait_rdy_b(input string req);
    int seen = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_b); #1;
      if (rdy_b) seen = 1;
    end
    chk(req, seen, 1);
  endtask

  task automatic run_preset(input logic [1:0] s);
    int e;
    e = exp_preset(1'b1, s);
    apply_reset(1'b1, s);
    @(posedge clk_a); #1;
    chk("R1 preset rdy_a", int'(wr_ready), 1);
    cfg_mode = 1'b0; cfg_sel = 2'($urandom_range(0, 3));
    chk_ofs("R1 preset value", e, e, e, e);
    chk("R9 no err preset", int'(mode_err), 0);
    wait_rdy_b("R6 rdy_b preset");
    repeat (3) @(posedge clk_a); #1;
    chk_ofs("R8 pins ignored after release", e, e, e, e);
  endtask

  task automatic run_parallel();
    int v[4];
    for (int k = 0; k < 4; k++) v[k] = $urandom_range(1, 252);
    apply_reset(1'b1, 2'b00);
    @(posedge clk_a); #1;
    chk("R2 parallel rdy_a", int'(wr_ready), 1);
    for (int k = 0; k < 4; k++) begin
      int gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk_a);
        wr_valid = 1'b0; wr_data = W'($urandom);
      end
      @(negedge clk_a);
      wr_valid = 1'b1; wr_data = W'(v[k]);
      #1;
      if (k == 3) begin
        chk("R3 loading write not forwarded", int'(mem_wr_valid), 0);
        chk("R6 rdy_b low before load done", int'(rdy_b), 0);
      end
    end
    @(negedge clk_a);
    wr_valid = 1'b0; wr_data = W'($urandom);
    #1;
    chk_ofs("R2 parallel order", v[0], v[1], v[2], v[3]);
    chk("R9 no err parallel", int'(mode_err), 0);
    wait_rdy_b("R6 rdy_b parallel");
    @(negedge clk_a);
    wr_valid = 1'b1; wr_data = W'($urandom);
    #1;
    chk("R3 pass-through write", int'(mem_wr_valid), 1);
    @(negedge clk_a);
    wr_valid = 1'b0;
    #1;
    chk_ofs("R3 offsets frozen", v[0], v[1], v[2], v[3]);
  endtask

  task automatic run_serial();
    int v[4];
    logic [4*W-1:0] word;
    for (int k = 0; k < 4; k++) v[k] = $urandom_range(1, 252);
    word = {W'(v[0]), W'(v[1]), W'(v[2]), W'(v[3])};
    apply_reset(1'b0, 2'b10);
    for (int i = 4*W-1; i >= 0; i--) begin
      int gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk_a);
        ser_en_n = 1'b1; ser_din = 1'($urandom);
      end
      @(negedge clk_a);
      ser_en_n = 1'b0; ser_din = word[i];
      if (i == 2*W) begin
        wr_valid = 1'b1;
        #1;
        chk("R5 no forward while not ready", int'(mem_wr_valid), 0);
      end
    end
    @(negedge clk_a);
    ser_en_n = 1'b1; ser_din = 1'($urandom); wr_valid = 1'b0;
    #1;
    chk("R5 rdy_a low at last bit", int'(wr_ready), 0);
    chk("R6 rdy_b low at last bit", int'(rdy_b), 0);
    chk_ofs("R4 serial order", v[0], v[1], v[2], v[3]);
    @(posedge clk_a); #1;
    chk("R5 rdy_a after last bit", int'(wr_ready), 1);
    chk("R9 no err serial", int'(mode_err), 0);
    wait_rdy_b("R6 rdy_b serial");
    @(negedge clk_a);
    ser_en_n = 1'b0; ser_din = ~ser_din;
    repeat (2) @(negedge clk_a);
    ser_en_n = 1'b1;
    #1;
    chk_ofs("R4 shifts ignored after load", v[0], v[1], v[2], v[3]);
  endtask

  task automatic run_reserved(input logic [1:0] s);
    apply_reset(1'b0, s);
    @(posedge clk_a); #1;
    chk("R7 err set", int'(mode_err), 1);
    cfg_mode = 1'b1; cfg_sel = 2'b00;
    ser_en_n = 1'b0; wr_valid = 1'b1;
    repeat (8) @(posedge clk_a);
    #1;
    chk("R7 err sticky", int'(mode_err), 1);
    chk("R7 rdy_a low", int'(wr_ready), 0);
    chk("R7 rdy_b low", int'(rdy_b), 0);
    chk_ofs("R7 default offsets", 64, 64, 64, 64);
    ser_en_n = 1'b1; wr_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PER * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0f5e_1d42));
    run_preset(2'b11);
    run_preset(2'b10);
    run_preset(2'b01);
    for (int t = 0; t < 3; t++) run_parallel();
    for (int t = 0; t < 3; t++) run_serial();
    run_reserved(2'b00);
    run_reserved(2'b01);
    run_reserved(2'b11);
    run_preset(2'b11);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule